// File: doc/BRIEF.md
# Phase-Sliced Character RAM Arbiter

This block lets a processor and a text-mode refresh engine use one 2 KiB character RAM without stalling either of them. The design clock runs at twice the processor cycle rate. Each processor cycle is split into two halves. In the first half the refresh engine owns the RAM address and fetches one character. In the second half the processor owns the address and may read or write. Because the two owners never compete, a processor access to character memory takes exactly one processor cycle, the same as any other memory. The refresh engine is never starved, so the displayed picture is never corrupted.

The refresh address is formed from a text column (0..79) and a text row (0..15). The row occupies the low four address bits and the column the bits above them, so characters that are next to each other on one line sit 16 bytes apart. Column codes 80..127 are never fetched by the refresh engine, so those 768 bytes are free working storage for the processor. Display timing, glyph generation and pixel shifting are handled elsewhere. This block only steers the address and data and generates the column/row scan.

Top module: `vri_interleaver`

## Requirements
- R1: While `rst_n` is low, `cpu_slot`, `vid_col`, `vid_row`, `vid_data` and `cpu_rdata` are all 0.
- R2: After reset the first clock edge ends a refresh half. `cpu_slot` then alternates 1, 0, 1, ... on every clock, and is 1 while the processor half is in progress.
- R3: At the end of each refresh half, `vid_data` loads the RAM byte at address `vid_col*16 + vid_row`. It holds that value through the following processor half.
- R4: At the end of each processor half, `vid_col` increases by one. It wraps from 79 to 0, and it never shows a value above 79.
- R5: When `vid_col` wraps, `vid_row` increases by one, wrapping from 15 to 0. At all other times `vid_row` is unchanged.
- R6: A write of `cpu_wdata` to `cpu_addr` takes effect at the end of a processor half in which `cpu_we` is 1. If `cpu_we` is 1 during a refresh half, the RAM is not changed.
- R7: At the end of each processor half, `cpu_rdata` loads the byte stored at `cpu_addr` before any write on that edge. It holds that value through the next refresh half, so every access completes in one processor cycle with no wait.
- R8: Addresses 1280..2047 (column field 80..127) read back what was written there. Their contents never appear on `vid_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock, two per processor cycle |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized on release |
| cpu_addr | input | 11 | Processor byte address |
| cpu_we | input | 1 | Processor write request |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte, captured at end of processor half |
| cpu_slot | output | 1 | 1 during the processor half of the cycle |
| vid_col | output | 7 | Current refresh text column |
| vid_row | output | 4 | Current refresh text row |
| vid_data | output | 8 | Character fetched in the last refresh half |

## Verification
First, every address is filled through the processor port with a pattern that encodes the column. This lets a full screen sweep show whether each fetched byte came from the right `col*16+row` location, and not from a row-major layout. Next, a write request is raised only in the refresh half, which shows whether writes are gated by phase or pass straight through. A full frame is then watched for the scratch marker byte, to confirm that the column range ends at 79. Last, a long run of mixed reads and writes to random addresses, including back-to-back accesses to the same byte, is compared against a behavioural model on every clock. This separates read-before-write capture from read-after-write capture.

// File: rtl/vri_pkg.sv
package vri_pkg;
  typedef enum logic {
    PH_REFRESH = 1'b0,
    PH_CPU     = 1'b1
  } phase_e;
endpackage

// File: rtl/vri_refresh_ctr.sv
module vri_refresh_ctr #(
  parameter int COLS  = 80,
  parameter int ROWS  = 16,
  parameter int COL_W = 7,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    if (adv) begin
      if (col_q == COL_LAST) begin
        col_d = '0;
        if (row_q == ROW_LAST) row_d = '0;
        else                   row_d = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
    end else if (adv) begin
      col_q <= col_d;
      row_q <= row_d;
    end
  end

  assign col = col_q;
  assign row = row_q;

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col_q < COL_W'(COLS)); // R4
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && col_q == COL_LAST) |=> (col_q == '0)); // R4
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && col_q == COL_LAST && row_q == ROW_LAST) |=> (row_q == '0)); // R5
  AST_ROW_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && col_q != COL_LAST) |=> $stable(row_q)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(col_q) && $stable(row_q))); // R4
endmodule

// File: rtl/vri_addr_mux.sv
module vri_addr_mux #(
  parameter int COL_W = 7,
  parameter int ROW_W = 4,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              sel_cpu,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] ram_addr
);
  logic [ADDR_W-1:0] scan_addr;

  // Row in the low bits: horizontally adjacent characters are 2**ROW_W apart.
  assign scan_addr = {col, row};
  assign ram_addr  = sel_cpu ? cpu_addr : scan_addr;
endmodule

// File: rtl/vri_ram.sv
module vri_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_slot,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  AST_WR_IN_CPU_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> cpu_slot); // R6
endmodule

// File: rtl/vri_interleaver.sv
module vri_interleaver #(
  parameter int DATA_W = 8,
  parameter int COLS   = 80,
  parameter int ROWS   = 16,
  parameter int COL_W  = 7,
  parameter int ROW_W  = 4,
  localparam int ADDR_W = COL_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_slot,
  output logic [COL_W-1:0]  vid_col,
  output logic [ROW_W-1:0]  vid_row,
  output logic [DATA_W-1:0] vid_data
);
  import vri_pkg::*;

  phase_e            phase_q, phase_d;
  logic              in_cpu;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_rd;
  logic              ram_we;
  logic [DATA_W-1:0] vid_q, cpu_q;

  assign in_cpu  = (phase_q == PH_CPU);
  assign phase_d = in_cpu ? PH_REFRESH : PH_CPU;
  assign ram_we  = cpu_we & in_cpu;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_REFRESH;
    else        phase_q <= phase_d;
  end

  vri_refresh_ctr #(.COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv(in_cpu), .col(vid_col), .row(vid_row)
  );

  vri_addr_mux #(.COL_W(COL_W), .ROW_W(ROW_W)) u_mux (
    .sel_cpu(in_cpu), .cpu_addr(cpu_addr), .col(vid_col), .row(vid_row),
    .ram_addr(ram_addr)
  );

  vri_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .cpu_slot(in_cpu), .we(ram_we), .addr(ram_addr),
    .wdata(cpu_wdata), .rdata(ram_rd)
  );

  // Refresh capture: enabled only at the end of the refresh half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vid_q <= '0;
    else if (!in_cpu) vid_q <= ram_rd;
  end

  // Processor capture: enabled only at the end of the processor half.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cpu_q <= '0;
    else if (in_cpu) cpu_q <= ram_rd;
  end

  assign cpu_slot  = in_cpu;
  assign vid_data  = vid_q;
  assign cpu_rdata = cpu_q;

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q != $past(phase_q))); // R2
  AST_VID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_cpu |=> $stable(vid_q)); // R3
  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_cpu |=> $stable(cpu_q)); // R7
endmodule

// File: tb/vri_interleaver_tb.sv
module vri_interleaver_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata, vid_data;
  logic        cpu_slot;
  logic [6:0]  vid_col;
  logic [3:0]  vid_row;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vri_interleaver u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_slot(cpu_slot),
    .vid_col(vid_col), .vid_row(vid_row), .vid_data(vid_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] mdl_mem [2048];
  bit         m_ph;
  int         m_col, m_row;
  logic [7:0] m_vid, m_cpu;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_col = 0; m_row = 0; m_vid = 0; m_cpu = 0;
    end else begin
      if (!m_ph) begin
        m_vid = mdl_mem[m_col * 16 + m_row];
      end else begin
        m_cpu = mdl_mem[cpu_addr];
        if (cpu_we) mdl_mem[cpu_addr] = cpu_wdata;
        m_col++;
        if (m_col == 80) begin
          m_col = 0;
          m_row = (m_row + 1) % 16;
        end
      end
      m_ph = !m_ph;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cpu_slot == m_ph, "R2 slot", cpu_slot, m_ph);
      chk(vid_col == m_col, "R4 col", vid_col, m_col);
      chk(vid_row == m_row, "R5 row", vid_row, m_row);
      if (!$isunknown(m_vid)) chk(vid_data === m_vid, "R3 vid", vid_data, m_vid);
      if (!$isunknown(m_cpu)) chk(cpu_rdata === m_cpu, "R7 cpu", cpu_rdata, m_cpu);
    end
  end

  function automatic logic [7:0] pat(input int a);
    return (a >= 1280) ? 8'hFF : 8'(a & 127);
  endfunction

  task automatic acc(input int a, input bit we, input logic [7:0] d, output logic [7:0] rd);
    do @(negedge clk); while (!cpu_slot);
    cpu_addr = 11'(a); cpu_we = we; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    rd = cpu_rdata;
  endtask

  initial begin
    logic [7:0] rd;
    int ff_seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpu_slot == 0 && vid_col == 0 && vid_row == 0 && vid_data == 0 && cpu_rdata == 0,
        "R1 reset", {cpu_slot, vid_col, vid_row}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_slot == 1, "R2 first half", cpu_slot, 1);

    for (int a = 0; a < 2048; a++) acc(a, 1'b1, pat(a), rd);

    // R6: write raised only during refresh half is ignored
    do @(negedge clk); while (cpu_slot);
    cpu_addr = 11'd100; cpu_we = 1'b1; cpu_wdata = 8'hEE;
    @(negedge clk);
    cpu_we = 1'b0;
    acc(100, 1'b0, 8'h00, rd);
    chk(rd == pat(100), "R6 refresh-half write ignored", rd, pat(100));
    // R6: write in processor half takes effect
    acc(200, 1'b1, 8'h33, rd);
    acc(200, 1'b0, 8'h00, rd);
    chk(rd == 8'h33, "R6 write commits", rd, 8'h33);
    acc(200, 1'b1, pat(200), rd);
    // R7: read-before-write on the same edge
    acc(300, 1'b1, 8'h44, rd);
    chk(rd == pat(300), "R7 old data on write edge", rd, pat(300));
    acc(300, 1'b1, pat(300), rd);

    // R8: scratch area readable, never shown
    acc(1300, 1'b0, 8'h00, rd);
    chk(rd == 8'hFF, "R8 scratch read", rd, 8'hFF);
    acc(2047, 1'b1, 8'hFF, rd);
    ff_seen = 0;
    repeat (2600) begin
      @(negedge clk);
      if (vid_data == 8'hFF) ff_seen++;
    end
    chk(ff_seen == 0, "R8 scratch never on display", ff_seen, 0);

    // Mixed traffic compared against the model each clock (R3 R4 R5 R6 R7)
    for (int i = 0; i < 1500; i++)
      acc(int'($urandom_range(0, 2047)), bit'($urandom_range(0, 1)),
          8'($urandom_range(0, 255)), rd);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1'b1;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule